// File: doc/BRIEF.md
# Three-Way Interleaved Frame Serializer

The block turns a 120-bit parallel frame into a serial stream that carries 120 bits per frame period. The frame is spread over three 40-bit shift registers, called lanes. Lane k holds frame bits k, k+3, k+6 and so on. A round-robin 3:1 selector visits lane 0, then lane 1, then lane 2, and puts the low bit of the chosen lane on the line. The lanes shift together only after the selector has visited all three. Only the selector therefore has to run at the full line rate; the lanes advance at one third of it.

The line timing comes from `bit_en`. Each clock cycle with `bit_en` high is one bit slot. A frame is offered by pulsing `frame_load` with `frame_data` on the same cycle. The block holds the offered frame until the current frame has finished. It then loads the frame into the lanes in the slot where the last bit of the current frame leaves, so frames follow each other with no gap. If no frame was offered, an all-zero idle frame goes out instead. `frame_sof` marks the slot that carries bit 0 of every frame, idle frames included.

Top module: `frame_interleave_ser`

## Requirements
- R1: After a synchronous reset, `ser_out` is 0 and `frame_sof` is 1. The first frame sent after reset is an idle frame of 120 zero bits.
- R2: The bits of a frame go out in index order: `frame_data[0]` first and `frame_data[119]` last.
- R3: Each cycle with `bit_en` high ends exactly one bit slot. A frame takes 120 slots.
- R4: A frame that is held for sending starts in the slot right after bit 119 of the previous frame. There is no gap slot between the two frames.
- R5: `frame_sof` is 1 exactly during the slots that carry bit 0 of a frame.
- R6: While `bit_en` is low, `ser_out` and `frame_sof` hold their values.
- R7: If no frame was strobed since the last frame load, the next frame sent is all zeros.
- R8: Suppose a `frame_load` strobe falls on the cycle that ends bit 119 of a frame, with `bit_en` high. The frame already held is sent next, and the newly strobed frame is sent in the frame after that.
- R9: If `frame_load` is pulsed several times before one load point, only the last frame offered is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-slot enable: each high cycle ends one serial bit slot |
| frame_load | input | 1 | Strobe that offers `frame_data` as the next frame |
| frame_data | input | 120 | Parallel frame; bit 0 is sent first |
| ser_out | output | 1 | Serial line bit |
| frame_sof | output | 1 | High during the slot that carries frame bit 0 |

## Verification
The assertions assume that `bit_en` and `frame_load` are sampled once per clock cycle. They also assume that `frame_data` matters only on cycles where the strobe is high. Nothing is required about the spacing of `bit_en` pulses or of strobes, so the properties must hold for any mix of the two. The stimulus changes every input only on the falling clock edge. It exercises `bit_en` tied high and `bit_en` pulsed sparsely. It places strobes in the middle of a frame, in the load cycle itself, and several times within one frame.

// File: rtl/fis_pkg.sv
package fis_pkg;
    localparam int FRAME_BITS = 120;
    localparam int NUM_LANES  = 3;

    typedef struct packed {
        logic adv;   // all lanes shift at the end of this slot
        logic load;  // all lanes reload at the end of this slot
        logic sof;   // this slot carries frame bit 0
    } slot_ctl_t;
endpackage

// File: rtl/fis_slot_ctr.sv
module fis_slot_ctr #(
    parameter int LANES  = 3,
    parameter int LANE_W = 40,
    localparam int SEL_W = $clog2(LANES),
    localparam int POS_W = $clog2(LANE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    output logic [SEL_W-1:0]  sel,
    output fis_pkg::slot_ctl_t ctl
);
    logic [POS_W-1:0] pos;

    always_comb begin
        ctl.adv  = bit_en && (sel == SEL_W'(LANES - 1));
        ctl.load = ctl.adv && (pos == POS_W'(LANE_W - 1));
        ctl.sof  = (sel == '0) && (pos == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            pos <= '0;
        end else if (bit_en) begin
            if (sel == SEL_W'(LANES - 1)) begin
                sel <= '0;
                pos <= (pos == POS_W'(LANE_W - 1)) ? '0 : pos + 1'b1;
            end else begin
                sel <= sel + 1'b1;
            end
        end
    end

    p_sel_range_r3: assert property (@(posedge clk) disable iff (rst)
        sel <= SEL_W'(LANES - 1));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(sel) && $stable(pos)));
    p_load_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> ctl.sof);
endmodule

// File: rtl/fis_frame_buf.sv
module fis_frame_buf #(
    parameter int W = 120
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         offer,
    input  logic [W-1:0] offer_data,
    input  logic         take,
    output logic         held_vld,
    output logic [W-1:0] next_frame
);
    logic [W-1:0] held;

    assign next_frame = held_vld ? held : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            held_vld <= 1'b0;
        end else begin
            if (offer) begin
                held     <= offer_data;
                held_vld <= 1'b1;
            end else if (take) begin
                held_vld <= 1'b0;
            end
        end
    end

    p_offer_kept_r8: assert property (@(posedge clk) disable iff (rst)
        offer |=> held_vld);
endmodule

// File: rtl/fis_lane.sv
module fis_lane #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         head
);
    logic [W-1:0] q;

    assign head = q[0];

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
        else if (adv)
            q <= {1'b0, q[W-1:1]};
    end

    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (q[W-2:0] == $past(q[W-1:1])));
endmodule

// File: rtl/frame_interleave_ser.sv
module frame_interleave_ser #(
    parameter int FRAME_W = fis_pkg::FRAME_BITS,
    parameter int LANES   = fis_pkg::NUM_LANES,
    localparam int LANE_W = FRAME_W / LANES,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               frame_load,
    input  logic [FRAME_W-1:0] frame_data,
    output logic               ser_out,
    output logic               frame_sof
);
    fis_pkg::slot_ctl_t ctl;
    logic [SEL_W-1:0]   sel;
    logic               held_vld;
    logic [FRAME_W-1:0] next_frame;
    logic [LANES-1:0]   heads;

    fis_slot_ctr #(.LANES(LANES), .LANE_W(LANE_W)) u_ctr (
        .clk(clk), .rst(rst), .bit_en(bit_en), .sel(sel), .ctl(ctl)
    );

    fis_frame_buf #(.W(FRAME_W)) u_buf (
        .clk(clk), .rst(rst), .offer(frame_load), .offer_data(frame_data),
        .take(ctl.load), .held_vld(held_vld), .next_frame(next_frame)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] din;
        for (genvar j = 0; j < LANE_W; j++) begin : g_bit
            assign din[j] = next_frame[j*LANES + k];
        end
        fis_lane #(.W(LANE_W)) u_lane (
            .clk(clk), .rst(rst), .adv(ctl.adv), .load(ctl.load),
            .din(din), .head(heads[k])
        );
    end

    always_comb begin
        ser_out = 1'b0;
        for (int k = 0; k < LANES; k++)
            if (sel == SEL_W'(k)) ser_out = heads[k];
    end
    assign frame_sof = ctl.sof;

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && !held_vld && !frame_load) |=> (!ser_out && frame_sof));
    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(ser_out) && $stable(frame_sof)));
    p_sof_once_r5: assert property (@(posedge clk) disable iff (rst)
        (frame_sof && bit_en) |=> !frame_sof);
endmodule

// File: tb/frame_interleave_ser_tb.sv
module frame_interleave_ser_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bit_en = 1'b0;
    logic         frame_load = 1'b0;
    logic [119:0] frame_data = '0;
    logic         ser_out;
    logic         frame_sof;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench model, built from the requirements
    int           m_cnt = 0;
    logic [119:0] m_cur = '0;
    logic [119:0] m_held = '0;
    bit           m_vld = 1'b0;

    always #5 clk = ~clk;

    frame_interleave_ser u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .frame_load(frame_load),
        .frame_data(frame_data), .ser_out(ser_out), .frame_sof(frame_sof)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: got %b expected %b", tag, m_cnt, act, exp);
        end
    endtask

    // called at a falling edge: checks outputs, applies inputs, advances one cycle
    task automatic step(input logic en, input logic ld, input logic [119:0] d,
                        input string tag);
        check(tag, ser_out, m_cur[m_cnt]);
        check("R5", frame_sof, m_cnt == 0);
        bit_en = en;
        frame_load = ld;
        frame_data = d;
        if (en && m_cnt == 119) begin
            m_cur = m_vld ? m_held : '0;
            m_vld = 1'b0;
        end
        if (ld) begin
            m_held = d;
            m_vld  = 1'b1;
        end
        if (en) m_cnt = (m_cnt + 1) % 120;
        @(negedge clk);
    endtask

    task automatic run_to_end(input string tag);
        while (m_cnt != 0) step(1'b1, 1'b0, '0, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", ser_out, 1'b0);
        check("R1", frame_sof, 1'b1);
        rst = 1'b0;
        m_cnt = 0; m_cur = '0; m_held = '0; m_vld = 1'b0;
        // idle first frame after reset
        for (int i = 0; i < 120; i++) step(1'b1, 1'b0, '0, "R1");
    endtask

    task automatic t_order;
        logic [119:0] walk;
        walk = {40{3'b001}} ^ 120'h1;
        walk[119] = 1'b1;
        step(1'b1, 1'b1, walk, "R2");
        run_to_end("R2");
        for (int i = 0; i < 120; i++) step(1'b1, 1'b0, '0, "R2");
    endtask

    task automatic t_back_to_back;
        logic [119:0] pat;
        for (int f = 0; f < 3; f++) begin
            pat = {4{30'h2A5C_3F17}} ^ {120{f[0]}} ^ (120'h1 << f);
            step(1'b1, 1'b1, pat, "R4");
            run_to_end("R4");
        end
        run_to_end("R4");
        for (int i = 0; i < 120; i++) step(1'b1, 1'b0, '0, "R4");
    endtask

    task automatic t_idle;
        for (int i = 0; i < 240; i++) step(1'b1, 1'b0, '0, "R7");
    endtask

    task automatic t_sparse_en;
        step(1'b0, 1'b1, {3{40'hF0_0F35_CA96}}, "R6");
        for (int i = 0; i < 3 * 260; i++) step((i % 3) == 2, 1'b0, '0, "R6");
        run_to_end("R3");
        for (int i = 0; i < 120; i++) step(1'b1, 1'b0, '0, "R3");
    endtask

    task automatic t_load_cycle;
        step(1'b1, 1'b1, {60{2'b10}}, "R8");
        while (m_cnt != 119) step(1'b1, 1'b0, '0, "R8");
        step(1'b1, 1'b1, {30{4'b1100}}, "R8");
        for (int i = 0; i < 360; i++) step(1'b1, 1'b0, '0, "R8");
    endtask

    task automatic t_latest_wins;
        step(1'b1, 1'b1, {120{1'b1}}, "R9");
        step(1'b0, 1'b1, {12{10'h3A7}}, "R9");
        step(1'b1, 1'b1, {8{15'h6B21}}, "R9");
        run_to_end("R9");
        for (int i = 0; i < 240; i++) step(1'b1, 1'b0, '0, "R9");
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_order;
        t_back_to_back;
        t_idle;
        t_sparse_en;
        t_load_cycle;
        t_latest_wins;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule